// File: doc/BRIEF.md
# Real-Time-Clock Register Access Monitor

This block watches a stream of I2C bus events that an upstream decoder has already extracted from the wire. It follows the accesses a bus master makes to the register file of a real-time-clock device. It is passive: it never drives the bus. Each event arrives as a one-cycle strobe carrying a type code and a data byte.

The block tracks a single register pointer. The master sets the pointer with the first data byte after an address-write. Every data byte that follows is applied to the register the pointer selects, and the pointer then advances. A repeated start after the pointer has been set turns the transaction into a read, and the same pointer carries on into it. Date and time fields are converted from BCD to binary as they pass by, and the block also captures the interrupt/timer status bits and the supply-low flag.

When a stop closes a write or a read, the block raises a one-cycle report pulse of the matching kind. At the same moment it presents the captured date and time, together with a mask that shows which fields were touched in that transaction.

Top module: `rtc_txn_monitor`

## Requirements
- R1: After reset both report pulses are low, every date/time output is all ones, the valid mask is zero, and the status bits and supply-low flag are zero.
- R2: Event codes are 1 start, 2 repeated start, 3 stop, 4 address-write, 5 address-read, 6 data-write, 7 data-read, and 0 is ignored. The sequence start, address-write, data-write loads the pointer. Each further data-write is applied to the pointed register and then advances the pointer. A stop then gives `doneWrite` high in the cycle after the stop event.
- R3: A repeated start in the write phase waits for an address-read. Data-read bytes after it are applied from the shared pointer and advance it. A stop then gives `doneRead` high in the cycle after the stop event.
- R4: The time fields are converted to binary as (low nibble) + 10 × (high nibble). They are taken from: seconds, bits 6:0 of register 0x02; minutes, bits 6:0 of 0x03; hours, bits 5:0 of 0x04; day of month, bits 5:0 of 0x05; month, bits 4:0 of 0x07; year, bits 7:0 of 0x08.
- R5: Bits 4:0 of register 0x01 appear on `statusBits` in the same positions. Bit 7 of register 0x02 appears on `lowVoltage`.
- R6: Every start event resets all six date/time fields to all ones. At a report, `validMask` bit i is set only if field i was written in that transaction. The bit order is 0 seconds, 1 minutes, 2 hours, 3 day, 4 month, 5 year.
- R7: Registers 0x00, 0x06, 0x09 to 0x0F and every address above 0x0F update nothing, but each access to them still advances the pointer. The pointer wraps from 0xFF to 0x00.
- R8: In idle, every event other than start is ignored. In a waiting or transfer state, an event that is not expected there is ignored and leaves the state unchanged. A start restarts the sequence from any state.
- R9: The report pulses are one clock wide and never high together. All report outputs hold their values between reports.
- R10: An event presented while `evValid` is low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| evValid | input | 1 | Event strobe |
| evType | input | 3 | Event type code |
| evData | input | 8 | Byte carried by a data event |
| doneWrite | output | 1 | One-cycle pulse: a write transaction completed |
| doneRead | output | 1 | One-cycle pulse: a read transaction completed |
| outSec | output | 7 | Seconds, binary |
| outMin | output | 7 | Minutes, binary |
| outHour | output | 6 | Hours, binary |
| outDay | output | 6 | Day of month, binary |
| outMonth | output | 5 | Month, binary |
| outYear | output | 8 | Year within century, binary |
| validMask | output | 6 | Fields written in the reported transaction |
| statusBits | output | 5 | Captured interrupt/timer status bits |
| lowVoltage | output | 1 | Captured supply-low flag |

## Verification
The internal state stays hidden until a stop closes the transaction. A wrong control state therefore first shows as a report pulse of the wrong kind, or a missing pulse, one cycle after the stop. A pointer that is off by one shows on that same report as values moved into the neighbouring field and a shifted valid mask. The outputs are compared after every event, so a report output that changes between reports is caught within one event.

// File: rtl/rtc_mon_pkg.sv
package rtc_mon_pkg;
  localparam int BYTE_W = 8;
  localparam int STAT_W = 5;
  localparam int NUM_FIELDS = 6;

  localparam logic [BYTE_W-1:0] ADDR_STATUS = 8'h01;
  localparam logic [BYTE_W-1:0] ADDR_SEC    = 8'h02;
  localparam logic [BYTE_W-1:0] ADDR_MIN    = 8'h03;
  localparam logic [BYTE_W-1:0] ADDR_HOUR   = 8'h04;
  localparam logic [BYTE_W-1:0] ADDR_DAY    = 8'h05;
  localparam logic [BYTE_W-1:0] ADDR_MONTH  = 8'h07;
  localparam logic [BYTE_W-1:0] ADDR_YEAR   = 8'h08;

  typedef enum logic [2:0] {
    EV_NONE    = 3'd0,
    EV_START   = 3'd1,
    EV_RSTART  = 3'd2,
    EV_STOP    = 3'd3,
    EV_ADDR_WR = 3'd4,
    EV_ADDR_RD = 3'd5,
    EV_DATA_WR = 3'd6,
    EV_DATA_RD = 3'd7
  } evKind_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_AW,
    ST_WAIT_PTR,
    ST_WRITE,
    ST_WAIT_AR,
    ST_READ
  } monState_t;

  typedef struct packed {
    logic clearFields;
    logic loadPtr;
    logic applyByte;
    logic reportWrite;
    logic reportRead;
  } ctrlStrobe_t;
endpackage

// File: rtl/rtc_mon_ctrl.sv
module rtc_mon_ctrl
  import rtc_mon_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        evValid,
  input  logic [2:0]  evType,
  output ctrlStrobe_t strobe
);
  monState_t curState, nextState;
  evKind_t   kind;

  assign kind = evKind_t'(evType);

  always_comb begin
    nextState = curState;
    strobe    = '0;
    if (evValid) begin
      if (kind == EV_START) begin
        // a start restarts the sequence from any state
        nextState          = ST_WAIT_AW;
        strobe.clearFields = 1'b1;
      end else begin
        case (curState)
          ST_WAIT_AW: if (kind == EV_ADDR_WR) nextState = ST_WAIT_PTR;
          ST_WAIT_PTR: begin
            if (kind == EV_DATA_WR) begin
              strobe.loadPtr = 1'b1;
              nextState      = ST_WRITE;
            end
          end
          ST_WRITE: begin
            if (kind == EV_DATA_WR) begin
              strobe.applyByte = 1'b1;
            end else if (kind == EV_RSTART) begin
              nextState = ST_WAIT_AR;
            end else if (kind == EV_STOP) begin
              strobe.reportWrite = 1'b1;
              nextState          = ST_IDLE;
            end
          end
          ST_WAIT_AR: if (kind == EV_ADDR_RD) nextState = ST_READ;
          ST_READ: begin
            if (kind == EV_DATA_RD) begin
              strobe.applyByte = 1'b1;
            end else if (kind == EV_STOP) begin
              strobe.reportRead = 1'b1;
              nextState         = ST_IDLE;
            end
          end
          default: nextState = curState;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) curState <= ST_IDLE;
    else       curState <= nextState;
  end
endmodule

// File: rtl/rtc_mon_field.sv
module rtc_mon_field
  import rtc_mon_pkg::*;
#(
  parameter int                FIELD_W    = 7,
  parameter int                SRC_W      = 7,
  parameter logic [BYTE_W-1:0] FIELD_ADDR = 8'h02
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               clearFields,
  input  logic               applyByte,
  input  logic [BYTE_W-1:0]  ptr,
  input  logic [BYTE_W-1:0]  dataByte,
  output logic [FIELD_W-1:0] fieldVal
);
  localparam logic [BYTE_W-1:0] SRC_MASK = BYTE_W'((1 << SRC_W) - 1);

  logic [BYTE_W-1:0]  srcBits;
  logic [FIELD_W-1:0] binVal;

  assign srcBits = dataByte & SRC_MASK;
  assign binVal  = FIELD_W'({4'd0, srcBits[3:0]} + (8'd10 * {4'd0, srcBits[7:4]}));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                   fieldVal <= '1;
    else if (clearFields)                        fieldVal <= '1;
    else if (applyByte && (ptr == FIELD_ADDR))   fieldVal <= binVal;
  end
endmodule

// File: rtl/rtc_mon_datapath.sv
module rtc_mon_datapath
  import rtc_mon_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStrobe_t           strobe,
  input  logic [BYTE_W-1:0]     evData,
  output logic                  doneWrite,
  output logic                  doneRead,
  output logic [6:0]            outSec,
  output logic [6:0]            outMin,
  output logic [5:0]            outHour,
  output logic [5:0]            outDay,
  output logic [4:0]            outMonth,
  output logic [7:0]            outYear,
  output logic [NUM_FIELDS-1:0] validMask,
  output logic [STAT_W-1:0]     statusBits,
  output logic                  lowVoltage
);
  logic [BYTE_W-1:0] ptr;
  logic [STAT_W-1:0] statReg;
  logic              lvReg;
  logic [6:0]        secBin, minBin;
  logic [5:0]        hourBin, dayBin;
  logic [4:0]        monthBin;
  logic [7:0]        yearBin;
  logic              reportAny;

  assign reportAny = strobe.reportWrite | strobe.reportRead;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 ptr <= '0;
    else if (strobe.loadPtr)   ptr <= evData;
    else if (strobe.applyByte) ptr <= ptr + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statReg <= '0;
      lvReg   <= 1'b0;
    end else if (strobe.applyByte) begin
      if (ptr == ADDR_STATUS) statReg <= evData[STAT_W-1:0];
      if (ptr == ADDR_SEC)    lvReg   <= evData[BYTE_W-1];
    end
  end

  rtc_mon_field #(.FIELD_W(7), .SRC_W(7), .FIELD_ADDR(ADDR_SEC)) u_sec (
    .clk(clk), .rstN(rstN), .clearFields(strobe.clearFields), .applyByte(strobe.applyByte),
    .ptr(ptr), .dataByte(evData), .fieldVal(secBin));
  rtc_mon_field #(.FIELD_W(7), .SRC_W(7), .FIELD_ADDR(ADDR_MIN)) u_min (
    .clk(clk), .rstN(rstN), .clearFields(strobe.clearFields), .applyByte(strobe.applyByte),
    .ptr(ptr), .dataByte(evData), .fieldVal(minBin));
  rtc_mon_field #(.FIELD_W(6), .SRC_W(6), .FIELD_ADDR(ADDR_HOUR)) u_hour (
    .clk(clk), .rstN(rstN), .clearFields(strobe.clearFields), .applyByte(strobe.applyByte),
    .ptr(ptr), .dataByte(evData), .fieldVal(hourBin));
  rtc_mon_field #(.FIELD_W(6), .SRC_W(6), .FIELD_ADDR(ADDR_DAY)) u_day (
    .clk(clk), .rstN(rstN), .clearFields(strobe.clearFields), .applyByte(strobe.applyByte),
    .ptr(ptr), .dataByte(evData), .fieldVal(dayBin));
  rtc_mon_field #(.FIELD_W(5), .SRC_W(5), .FIELD_ADDR(ADDR_MONTH)) u_month (
    .clk(clk), .rstN(rstN), .clearFields(strobe.clearFields), .applyByte(strobe.applyByte),
    .ptr(ptr), .dataByte(evData), .fieldVal(monthBin));
  rtc_mon_field #(.FIELD_W(8), .SRC_W(8), .FIELD_ADDR(ADDR_YEAR)) u_year (
    .clk(clk), .rstN(rstN), .clearFields(strobe.clearFields), .applyByte(strobe.applyByte),
    .ptr(ptr), .dataByte(evData), .fieldVal(yearBin));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      doneWrite  <= 1'b0;
      doneRead   <= 1'b0;
      outSec     <= '1;
      outMin     <= '1;
      outHour    <= '1;
      outDay     <= '1;
      outMonth   <= '1;
      outYear    <= '1;
      validMask  <= '0;
      statusBits <= '0;
      lowVoltage <= 1'b0;
    end else begin
      doneWrite <= strobe.reportWrite;
      doneRead  <= strobe.reportRead;
      if (reportAny) begin
        outSec     <= secBin;
        outMin     <= minBin;
        outHour    <= hourBin;
        outDay     <= dayBin;
        outMonth   <= monthBin;
        outYear    <= yearBin;
        validMask  <= {yearBin != '1, monthBin != '1, dayBin != '1,
                       hourBin != '1, minBin != '1, secBin != '1};
        statusBits <= statReg;
        lowVoltage <= lvReg;
      end
    end
  end
endmodule

// File: rtl/rtc_txn_monitor.sv
module rtc_txn_monitor
  import rtc_mon_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       evValid,
  input  logic [2:0] evType,
  input  logic [7:0] evData,
  output logic       doneWrite,
  output logic       doneRead,
  output logic [6:0] outSec,
  output logic [6:0] outMin,
  output logic [5:0] outHour,
  output logic [5:0] outDay,
  output logic [4:0] outMonth,
  output logic [7:0] outYear,
  output logic [5:0] validMask,
  output logic [4:0] statusBits,
  output logic       lowVoltage
);
  ctrlStrobe_t strobe;

  rtc_mon_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .evValid(evValid), .evType(evType), .strobe(strobe));

  rtc_mon_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .evData(evData),
    .doneWrite(doneWrite), .doneRead(doneRead),
    .outSec(outSec), .outMin(outMin), .outHour(outHour), .outDay(outDay),
    .outMonth(outMonth), .outYear(outYear), .validMask(validMask),
    .statusBits(statusBits), .lowVoltage(lowVoltage));
endmodule

// File: rtl/rtc_txn_monitor_chk.sv
module rtc_txn_monitor_chk (
  input logic       clk,
  input logic       rstN,
  input logic       evValid,
  input logic [2:0] evType,
  input logic       doneWrite,
  input logic       doneRead,
  input logic [6:0] outSec,
  input logic [6:0] outMin,
  input logic [7:0] outYear,
  input logic [5:0] validMask,
  input logic [4:0] statusBits
);
  p_done_excl_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(doneWrite && doneRead));

  p_wr_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    doneWrite |=> !doneWrite);

  p_rd_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    doneRead |=> !doneRead);

  p_wr_after_stop_r2: assert property (@(posedge clk) disable iff (!rstN)
    doneWrite |-> $past(evValid && evType == 3'd3));

  p_rd_after_stop_r3: assert property (@(posedge clk) disable iff (!rstN)
    doneRead |-> $past(evValid && evType == 3'd3));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(doneWrite || doneRead) |-> ($stable(outSec) && $stable(outMin) && $stable(outYear)
                                  && $stable(validMask) && $stable(statusBits)));

  p_sec_mask_r6: assert property (@(posedge clk) disable iff (!rstN)
    validMask[0] |-> outSec != 7'h7F);

  p_min_mask_r6: assert property (@(posedge clk) disable iff (!rstN)
    validMask[1] |-> outMin != 7'h7F);

  p_no_strobe_r10: assert property (@(posedge clk) disable iff (!rstN)
    !$past(evValid) |-> !(doneWrite || doneRead));
endmodule

bind rtc_txn_monitor rtc_txn_monitor_chk u_chk (
  .clk(clk), .rstN(rstN), .evValid(evValid), .evType(evType),
  .doneWrite(doneWrite), .doneRead(doneRead), .outSec(outSec), .outMin(outMin),
  .outYear(outYear), .validMask(validMask), .statusBits(statusBits));

// File: tb/rtc_txn_monitor_tb.sv
`timescale 1ns/1ps
module rtc_txn_monitor_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       evValid = 1'b0;
  logic [2:0] evType = 3'd0;
  logic [7:0] evData = 8'd0;
  logic       doneWrite, doneRead, lowVoltage;
  logic [6:0] outSec, outMin;
  logic [5:0] outHour, outDay, validMask;
  logic [4:0] outMonth, statusBits;
  logic [7:0] outYear;

  int nChk = 0;
  int nFail = 0;

  // reference model state
  int mState = 0, mPtr = 0, mStat = 0, mLv = 0;
  int fSec = 127, fMin = 127, fHour = 63, fDay = 63, fMon = 31, fYear = 255;
  int oSec = 127, oMin = 127, oHour = 63, oDay = 63, oMon = 31, oYear = 255;
  int oMask = 0, oStat = 0, oLv = 0, oDw = 0, oDr = 0;

  always #2.5 clk = ~clk;

  rtc_txn_monitor u_dut (
    .clk(clk), .rstN(rstN), .evValid(evValid), .evType(evType), .evData(evData),
    .doneWrite(doneWrite), .doneRead(doneRead), .outSec(outSec), .outMin(outMin),
    .outHour(outHour), .outDay(outDay), .outMonth(outMonth), .outYear(outYear),
    .validMask(validMask), .statusBits(statusBits), .lowVoltage(lowVoltage));

  function automatic int bcd(int b);
    return (b & 15) + 10 * ((b >> 4) & 15);
  endfunction

  task automatic modelApply(int b);
    case (mPtr)
      1: mStat = b & 31;
      2: begin fSec = bcd(b & 8'h7F); mLv = (b >> 7) & 1; end
      3: fMin  = bcd(b & 8'h7F);
      4: fHour = bcd(b & 8'h3F);
      5: fDay  = bcd(b & 8'h3F);
      7: fMon  = bcd(b & 8'h1F);
      8: fYear = bcd(b & 8'hFF);
      default: ;
    endcase
    mPtr = (mPtr + 1) & 255;
  endtask

  task automatic modelReport();
    oSec = fSec; oMin = fMin; oHour = fHour; oDay = fDay; oMon = fMon; oYear = fYear;
    oMask = (fSec != 127 ? 1 : 0) | (fMin != 127 ? 2 : 0) | (fHour != 63 ? 4 : 0)
          | (fDay != 63 ? 8 : 0) | (fMon != 31 ? 16 : 0) | (fYear != 255 ? 32 : 0);
    oStat = mStat; oLv = mLv;
  endtask

  task automatic modelStep(bit v, int t, int d);
    oDw = 0; oDr = 0;
    if (!v) return;
    if (t == 1) begin
      fSec = 127; fMin = 127; fHour = 63; fDay = 63; fMon = 31; fYear = 255;
      mState = 1;
      return;
    end
    case (mState)
      1: if (t == 4) mState = 2;
      2: if (t == 6) begin mPtr = d; mState = 3; end
      3: begin
        if (t == 6) modelApply(d);
        else if (t == 2) mState = 4;
        else if (t == 3) begin modelReport(); oDw = 1; mState = 0; end
      end
      4: if (t == 5) mState = 5;
      5: begin
        if (t == 7) modelApply(d);
        else if (t == 3) begin modelReport(); oDr = 1; mState = 0; end
      end
      default: ;
    endcase
  endtask

  task automatic chk(string tag, string name, int act, int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, name, act, exp);
    end
  endtask

  task automatic compareAll(string tag);
    chk(tag, "doneWrite", int'(doneWrite), oDw);
    chk(tag, "doneRead", int'(doneRead), oDr);
    chk(tag, "outSec", int'(outSec), oSec);
    chk(tag, "outMin", int'(outMin), oMin);
    chk(tag, "outHour", int'(outHour), oHour);
    chk(tag, "outDay", int'(outDay), oDay);
    chk(tag, "outMonth", int'(outMonth), oMon);
    chk(tag, "outYear", int'(outYear), oYear);
    chk(tag, "validMask", int'(validMask), oMask);
    chk(tag, "statusBits", int'(statusBits), oStat);
    chk(tag, "lowVoltage", int'(lowVoltage), oLv);
  endtask

  task automatic sendEv(bit v, int t, int d, string tag);
    @(negedge clk);
    evValid = v; evType = 3'(t); evData = 8'(d);
    @(negedge clk);
    modelStep(v, t, d);
    compareAll(tag);
    evValid = 1'b0;
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", nChk - nFail, nChk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    compareAll("R1");

    // R2 R4 R5: full write starting at the status register
    sendEv(1, 1, 0, "R2");
    sendEv(1, 4, 8'hA2, "R2");
    sendEv(1, 6, 8'h01, "R2");
    sendEv(1, 6, 8'h1B, "R5");
    sendEv(1, 6, 8'h85, "R5");
    sendEv(1, 6, 8'h59, "R4");
    sendEv(1, 6, 8'h23, "R4");
    sendEv(1, 6, 8'h31, "R4");
    sendEv(1, 6, 8'h06, "R4");
    sendEv(1, 6, 8'h12, "R4");
    sendEv(1, 6, 8'h99, "R4");
    sendEv(1, 3, 0, "R2");
    chk("R4", "year literal", int'(outYear), 99);
    chk("R5", "status literal", int'(statusBits), 5'h1B);

    // R3 R6: read of minutes and hours through repeated start
    sendEv(1, 1, 0, "R3");
    sendEv(1, 4, 8'hA2, "R3");
    sendEv(1, 6, 8'h03, "R3");
    sendEv(1, 2, 0, "R3");
    sendEv(1, 5, 8'hA3, "R3");
    sendEv(1, 7, 8'h07, "R3");
    sendEv(1, 7, 8'h14, "R3");
    sendEv(1, 3, 0, "R3");
    chk("R6", "mask literal", int'(validMask), 6);

    // R7: pointer wrap and ignored registers
    sendEv(1, 1, 0, "R7");
    sendEv(1, 4, 0, "R7");
    sendEv(1, 6, 8'hFE, "R7");
    sendEv(1, 6, 8'h55, "R7");
    sendEv(1, 6, 8'h55, "R7");
    sendEv(1, 6, 8'h0A, "R7");
    sendEv(1, 6, 8'h04, "R7");
    sendEv(1, 6, 8'h30, "R7");
    sendEv(1, 3, 0, "R7");
    chk("R7", "sec literal", int'(outSec), 30);

    // R8: ignored events and restart
    sendEv(1, 3, 0, "R8");
    sendEv(1, 1, 0, "R8");
    sendEv(1, 3, 0, "R8");
    sendEv(1, 6, 8'h02, "R8");
    sendEv(1, 4, 0, "R8");
    sendEv(1, 5, 0, "R8");
    sendEv(1, 6, 8'h08, "R8");
    sendEv(1, 6, 8'h21, "R8");
    sendEv(1, 1, 0, "R8");
    sendEv(1, 4, 0, "R8");
    sendEv(1, 6, 8'h05, "R8");
    sendEv(1, 6, 8'h09, "R8");
    sendEv(1, 2, 0, "R8");
    sendEv(1, 3, 0, "R8");
    sendEv(1, 7, 8'h44, "R8");
    sendEv(1, 5, 0, "R8");
    sendEv(1, 7, 8'h11, "R8");
    sendEv(1, 3, 0, "R8");
    chk("R8", "mask literal", int'(validMask), 8);

    // R10: strobe low events ignored
    sendEv(1, 1, 0, "R10");
    sendEv(1, 4, 0, "R10");
    sendEv(0, 6, 8'h02, "R10");
    sendEv(1, 6, 8'h08, "R10");
    sendEv(0, 6, 8'h77, "R10");
    sendEv(0, 3, 0, "R10");
    sendEv(1, 6, 8'h45, "R10");
    sendEv(1, 3, 0, "R10");

    // R9: random event stream against the model
    for (int i = 0; i < 3000; i++) begin
      int r, t, d;
      bit v;
      r = int'($urandom % 100);
      if (r < 4) t = 1;
      else if (r < 8) t = 2;
      else if (r < 14) t = 3;
      else if (r < 24) t = 4;
      else if (r < 32) t = 5;
      else if (r < 75) t = 6;
      else t = 7;
      if ($urandom % 10 == 0) t = 0;
      v = ($urandom % 10) != 0;
      d = ($urandom % 2 == 0) ? int'($urandom % 16) : int'($urandom % 256);
      sendEv(v, t, d, "R9");
    end

    summary();
    $finish;
  end
endmodule